// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates interrupt requests from seven sources and presents the winner to a processor as a single interrupt line plus a 5-bit vector. The sources are one timer source carrying three sub-requests, two DMA channel requests and four external requests. Each source owns a 4-bit control field: a 3-bit priority level in bits 2:0 and a mask bit in bit 3. A global 3-bit priority mask limits how deep into the levels the scan goes.

The processor takes an interrupt in one of two ways. It can pulse `inta`, or it can read the poll register through the register port. Either way the pending source moves into service. Software then retires the source with an end-of-interrupt (EOI) write, which is either specific (it names a vector) or non-specific (it clears the most urgent source in service).

The control core is a two-state machine. In ST_IDLE nothing is pending. The grant transition moves it to ST_PEND when the scan finds a winner. While in ST_PEND, a re-grant transition keeps the state and reloads the vector whenever the scan finds a winner again. The acknowledge transition returns it to ST_IDLE. Arbitration is re-evaluated on every clock.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Masking and priority limit. A source can win only when its full 4-bit control field equals the level being scanned. Levels are scanned from 0 up to and including the priority-mask value. So a source whose mask bit 3 is set never wins, and a source whose level is above the priority mask never wins.
- R2: Scan order. Lower levels are scanned first. Within one level the order is timer, then DMA0, then DMA1, then external inputs 0 to 3.
- R3: Vectors. Timer sub-request 0 gives 0x08, sub-request 1 gives 0x12 and sub-request 2 gives 0x13, and sub-request 0 is checked first. DMA0 gives 0x0A and DMA1 gives 0x0B. External inputs 0 to 3 give 0x0C to 0x0F.
- R4: In-service blocking. If the first source met in the scan that matches the current level has its in-service bit set, the scan stops and no new interrupt is raised. In-service and request bit positions are: timer bit 0, DMA0 bit 2, DMA1 bit 3, external inputs 0 to 3 at bits 4 to 7.
- R5: Grant. A request pulse is latched on one clock edge. On the next edge a grant loads poll status with 0x8000 ORed with the vector, and `irq` goes high.
- R6: Acknowledge. An acknowledge happens on an `inta` pulse, or on a read of the poll register, while an interrupt is pending. It does all of the following:
  - drives the vector on `ack_vec` during that cycle;
  - clears the source's request bit, or, for a timer vector, the matching timer status bit;
  - sets the source's in-service bit;
  - clears poll-status bit 15, so `irq` falls.
- R7: Specific EOI. A write to the EOI register with bit 15 low clears the in-service bit that matches the vector in bits 4:0. All three timer vectors map to bit 0.
- R8: Non-specific EOI. A write to the EOI register with bit 15 high clears the in-service bit of the source that has the lowest level and the earliest scan order among those in service. For this the level is taken from bits 2:0 of the control field, and the mask bit is ignored.
- R9: A read of the poll-status register returns poll status and does not acknowledge. `irq` and the in-service bits stay unchanged.
- R10: The mask register shows each source's control bit 3 at that source's in-service bit position. A write to the mask register changes only those bits.
- R11: After reset:
  - every control field is 0xF;
  - the priority mask is 7;
  - in-service, request, timer status and poll status are 0;
  - `irq` is low;
  - the mask register reads 0x00FD.
- R12: Register addresses. Reads of unlisted addresses return 0.

  | Address | Register | Access |
  |---|---|---|
  | 0 | EOI | write |
  | 1 | poll (acknowledges) | read |
  | 2 | poll status | read |
  | 3 | mask | read/write |
  | 4 | priority mask, bits 2:0 | read/write |
  | 5 | in-service, bits 7:0 | read/write |
  | 6 | request, with bit 0 = OR of timer status | read |
  | 7 | timer status, bits 2:0 | read/write |
  | 8 | timer control | read/write |
  | 9, 10 | DMA0, DMA1 control | read/write |
  | 11 to 14 | external 0 to 3 control | read/write |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_req | input | 3 | Timer sub-request pulses; they set timer status bits |
| dma_req | input | 2 | DMA channel request pulses |
| ext_req | input | 4 | External request pulses |
| inta | input | 1 | Interrupt acknowledge pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational) |
| irq | output | 1 | Interrupt pending to the processor |
| ack_vec | output | 5 | Vector of the pending interrupt; returned on acknowledge |

## Verification
The bench builds the controller with its default parameters: a 16-bit data word and a 4-bit register address. These defaults make the whole register map reachable, including the poll and poll-status registers and bit 15 of the EOI word.

A vector table drives combinations of requests from several sources. The chosen level assignment puts a DMA channel and an external input on the same level, and places the timer above some external inputs. This exercises both the order across levels and the order inside a level.

Directed sequences then cover the cases the table cannot reach:
- a masked source and a level above the priority mask;
- blocking by an in-service source at the same level;
- release of that block by a specific EOI;
- a non-specific EOI with two sources in service;
- acknowledge through the `inta` pin;
- a timer request raised by a register write.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int NSRC  = 7;
    localparam int SRC_W = $clog2(NSRC);
    localparam int LVL_W = 3;
    localparam int CTL_W = LVL_W + 1;
    localparam int VEC_W = 5;
    localparam int ISR_W = 8;
    localparam int NLVL  = 1 << LVL_W;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } pend_state_e;

    // register addresses; vector and bit positions are fixed by behaviour
    localparam logic [3:0] A_EOI   = 4'd0;
    localparam logic [3:0] A_POLL  = 4'd1;
    localparam logic [3:0] A_PSTAT = 4'd2;
    localparam logic [3:0] A_MASK  = 4'd3;
    localparam logic [3:0] A_PMASK = 4'd4;
    localparam logic [3:0] A_ISR   = 4'd5;
    localparam logic [3:0] A_REQ   = 4'd6;
    localparam logic [3:0] A_TSTAT = 4'd7;
    localparam logic [3:0] A_CTL0  = 4'd8;

    // source 0 is the timer, 1..2 the DMA channels, 3..6 the external inputs
    function automatic int unsigned src_bit(input int unsigned s);
        return (s == 0) ? 0 : s + 1;
    endfunction

    function automatic logic [VEC_W-1:0] src_vec(input logic [SRC_W-1:0] s,
                                                 input logic [2:0] ts);
        if (s == '0) begin
            if (ts[0])      return 5'h08;
            else if (ts[1]) return 5'h12;
            else            return 5'h13;
        end
        return VEC_W'(5'd9 + 5'(s));
    endfunction

    function automatic logic [ISR_W-1:0] vec_to_isr(input logic [VEC_W-1:0] v);
        if (v == 5'h08 || v == 5'h12 || v == 5'h13) return 8'h01;
        if (v >= 5'h0A && v <= 5'h0F) return 8'h01 << (v - 5'h08);
        return '0;
    endfunction

endpackage

// File: rtl/prio_scan.sv
module prio_scan
    import prio_irq_pkg::*;
(
    input  logic [NSRC-1:0][CTL_W-1:0] ctl,
    input  logic [LVL_W-1:0]           pmask,
    input  logic [ISR_W-1:0]           isr,
    input  logic [NSRC-1:0]            pend,
    output logic                       gnt_valid,
    output logic [SRC_W-1:0]           gnt_src
);
    logic stop;

    always_comb begin
        stop      = 1'b0;
        gnt_valid = 1'b0;
        gnt_src   = '0;
        for (int lv = 0; lv < NLVL; lv++) begin
            if (lv <= int'(pmask)) begin
                for (int s = 0; s < NSRC; s++) begin
                    if (!stop && ctl[s] == CTL_W'(lv)) begin
                        if (isr[src_bit(s)]) begin
                            stop = 1'b1;
                        end else if (pend[s]) begin
                            stop      = 1'b1;
                            gnt_valid = 1'b1;
                            gnt_src   = SRC_W'(s);
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/prio_eoi.sv
module prio_eoi
    import prio_irq_pkg::*;
(
    input  logic [NSRC-1:0][CTL_W-1:0] ctl,
    input  logic [ISR_W-1:0]           isr,
    input  logic                       nonspec,
    input  logic [VEC_W-1:0]           vec,
    output logic [ISR_W-1:0]           clr
);
    logic hit;

    always_comb begin
        hit = 1'b0;
        clr = '0;
        if (!nonspec) begin
            clr = vec_to_isr(vec);
        end else begin
            for (int lv = 0; lv < NLVL; lv++) begin
                for (int s = 0; s < NSRC; s++) begin
                    if (!hit && ctl[s][LVL_W-1:0] == LVL_W'(lv) && isr[src_bit(s)]) begin
                        hit = 1'b1;
                        clr[src_bit(s)] = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        tmr_req,
    input  logic [1:0]        dma_req,
    input  logic [3:0]        ext_req,
    input  logic              inta,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic [VEC_W-1:0]  ack_vec
);
    localparam logic [ISR_W-1:0] REQ_BITS = 8'hFC;

    pend_state_e                state_q;
    logic [NSRC-1:0][CTL_W-1:0] ctl_q;
    logic [LVL_W-1:0]           pmask_q;
    logic [ISR_W-1:0]           isr_q, req_q, isr_n, req_n, ack_mask, eoi_clr;
    logic [2:0]                 tstat_q, tstat_n, tclr;
    logic [VEC_W-1:0]           vec_q;
    logic [SRC_W-1:0]           src_q, gnt_src;
    logic [NSRC-1:0]            pend;
    logic                       gnt_valid, ack_fire, eoi_wr;
    logic [DATA_W-1:0]          pstat, mask_rd;
    logic                       unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-2:ISR_W];

    always_comb begin
        pend = '0;
        pend[0] = |tstat_q;
        for (int s = 1; s < NSRC; s++) pend[s] = req_q[src_bit(s)];
    end

    prio_scan u_scan (
        .ctl(ctl_q), .pmask(pmask_q), .isr(isr_q), .pend(pend),
        .gnt_valid(gnt_valid), .gnt_src(gnt_src)
    );

    prio_eoi u_eoi (
        .ctl(ctl_q), .isr(isr_q), .nonspec(reg_wdata[DATA_W-1]),
        .vec(reg_wdata[VEC_W-1:0]), .clr(eoi_clr)
    );

    assign ack_fire = (state_q == ST_PEND) &&
                      (inta || (reg_rd && reg_addr == ADDR_W'(A_POLL)));
    assign eoi_wr   = reg_wr && reg_addr == ADDR_W'(A_EOI);
    assign ack_mask = ISR_W'(1) << src_bit(src_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (gnt_valid) state_q <= ST_PEND;
                ST_PEND: if (ack_fire)  state_q <= ST_IDLE;
            endcase
        end
    end

    // vector latch: grant and re-grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            src_q <= '0;
        end else if (gnt_valid && !ack_fire) begin
            vec_q <= src_vec(gnt_src, tstat_q);
            src_q <= gnt_src;
        end
    end

    always_comb begin
        tclr = 3'b000;
        if (ack_fire && src_q == '0) begin
            case (vec_q)
                5'h08:   tclr = 3'b001;
                5'h12:   tclr = 3'b010;
                5'h13:   tclr = 3'b100;
                default: tclr = 3'b000;
            endcase
        end
        isr_n = isr_q;
        if (ack_fire) isr_n = isr_n | ack_mask;
        if (eoi_wr)   isr_n = isr_n & ~eoi_clr;
        if (reg_wr && reg_addr == ADDR_W'(A_ISR)) isr_n = reg_wdata[ISR_W-1:0];
        req_n = ((req_q & ~(ack_fire ? ack_mask : '0)) | {ext_req, dma_req, 2'b00}) & REQ_BITS;
        tstat_n = (tstat_q & ~tclr) | tmr_req;
        if (reg_wr && reg_addr == ADDR_W'(A_TSTAT)) tstat_n = reg_wdata[2:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q   <= '0;
            req_q   <= '0;
            tstat_q <= '0;
            pmask_q <= '1;
            ctl_q   <= '1;
        end else begin
            isr_q   <= isr_n;
            req_q   <= req_n;
            tstat_q <= tstat_n;
            if (reg_wr && reg_addr == ADDR_W'(A_PMASK)) pmask_q <= reg_wdata[LVL_W-1:0];
            for (int s = 0; s < NSRC; s++) begin
                if (reg_wr && reg_addr == ADDR_W'(A_MASK))
                    ctl_q[s][CTL_W-1] <= reg_wdata[src_bit(s)];
                if (reg_wr && reg_addr == ADDR_W'(int'(A_CTL0) + s))
                    ctl_q[s] <= reg_wdata[CTL_W-1:0];
            end
        end
    end

    // outputs
    always_comb begin
        irq     = (state_q == ST_PEND);
        ack_vec = vec_q;
        pstat   = '0;
        pstat[DATA_W-1]  = irq;
        pstat[VEC_W-1:0] = vec_q;
        mask_rd = '0;
        for (int s = 0; s < NSRC; s++) mask_rd[src_bit(s)] = ctl_q[s][CTL_W-1];
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_POLL) || reg_addr == ADDR_W'(A_PSTAT)) reg_rdata = pstat;
        else if (reg_addr == ADDR_W'(A_MASK))  reg_rdata = mask_rd;
        else if (reg_addr == ADDR_W'(A_PMASK)) reg_rdata = DATA_W'(pmask_q);
        else if (reg_addr == ADDR_W'(A_ISR))   reg_rdata = DATA_W'(isr_q);
        else if (reg_addr == ADDR_W'(A_REQ))   reg_rdata = DATA_W'(req_q | {7'b0, |tstat_q});
        else if (reg_addr == ADDR_W'(A_TSTAT)) reg_rdata = DATA_W'(tstat_q);
        else begin
            for (int s = 0; s < NSRC; s++)
                if (reg_addr == ADDR_W'(int'(A_CTL0) + s)) reg_rdata = DATA_W'(ctl_q[s]);
        end
    end

    // assertions
    p_ack_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> !irq);

    p_ack_sets_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !eoi_wr && !(reg_wr && reg_addr == ADDR_W'(A_ISR)))
        |=> (isr_q & $past(ack_mask)) != '0);

    p_spec_eoi_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !reg_wdata[DATA_W-1] && !ack_fire)
        |=> (isr_q & $past(vec_to_isr(reg_wdata[VEC_W-1:0]))) == '0);

    p_legal_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (vec_q inside {5'h08, 5'h12, 5'h13} || (vec_q >= 5'h0A && vec_q <= 5'h0F)));

    p_pstat_read_keeps_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && reg_rd && reg_addr == ADDR_W'(A_PSTAT) && !inta) |=> irq);

endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  tmr_req = '0;
    logic [1:0]  dma_req = '0;
    logic [3:0]  ext_req = '0;
    logic        inta = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;
    logic [4:0]  ack_vec;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tmr_req(tmr_req), .dma_req(dma_req),
        .ext_req(ext_req), .inta(inta), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .ack_vec(ack_vec)
    );

    // {tmr[2:0], dma[1:0], ext[3:0], expected first vector}
    localparam logic [13:0] TBL [8] = '{
        14'b000_00_0010_01101,  // ext1            -> 0D
        14'b000_01_0001_01100,  // ext0 + dma0     -> 0C (level 0)
        14'b000_10_1000_01011,  // dma1 + ext3     -> 0B (same level)
        14'b110_00_0000_10010,  // tmr2 + tmr1     -> 12
        14'b100_00_0010_10011,  // tmr2 + ext1     -> 13
        14'b000_00_0110_01110,  // ext2 + ext1     -> 0E
        14'b001_01_0000_01010,  // dma0 + tmr0     -> 0A
        14'b000_00_1000_01111   // ext3            -> 0F
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] t, input logic [1:0] dm, input logic [3:0] e);
        @(negedge clk);
        tmr_req = t; dma_req = dm; ext_req = e;
        @(negedge clk);
        tmr_req = '0; dma_req = '0; ext_req = '0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 irq", {15'b0, irq}, 16'h0000);
        rd(4'd2, d); check("R11 poll status", d, 16'h0000);
        rd(4'd3, d); check("R11 mask", d, 16'h00FD);
        rd(4'd4, d); check("R11 pmask", d, 16'h0007);
        rd(4'd5, d); check("R11 isr", d, 16'h0000);

        // level setup: timer 3, dma0 1, dma1 2, ext0 0, ext1 5, ext2 4, ext3 2 (R12 addresses)
        wr(4'd8, 16'h3); wr(4'd9, 16'h1); wr(4'd10, 16'h2);
        wr(4'd11, 16'h0); wr(4'd12, 16'h5); wr(4'd13, 16'h4); wr(4'd14, 16'h2);
        rd(4'd12, d); check("R12 ext1 ctl readback", d, 16'h0005);

        // table walk: R2 R3 R5 R6
        for (int i = 0; i < 8; i++) begin
            pulse(TBL[i][13:11], TBL[i][10:9], TBL[i][8:5]);
            settle();
            check("R5 irq after grant", {15'b0, irq}, 16'h0001);
            rd(4'd2, d); check("R2/R3 poll status", d, 16'h8000 | 16'(TBL[i][4:0]));
            rd(4'd1, d); check("R6 poll read vector", d, 16'h8000 | 16'(TBL[i][4:0]));
            wr(4'd0, 16'h8000);
            for (int k = 0; k < 8; k++) begin
                settle();
                if (irq) begin
                    rd(4'd1, d);
                    wr(4'd0, 16'h8000);
                end
            end
            settle();
            rd(4'd5, d); check("R8 drained isr", d, 16'h0000);
        end

        // R10 / R1 masking
        wr(4'd3, 16'h0010);
        rd(4'd11, d); check("R10 ext0 ctl bit3 via mask", d, 16'h0008);
        pulse(3'b000, 2'b00, 4'b0001);
        settle();
        check("R1 masked source no irq", {15'b0, irq}, 16'h0000);
        rd(4'd6, d); check("R1 request latched", d & 16'h0010, 16'h0010);
        wr(4'd3, 16'h0000);
        settle();
        rd(4'd2, d); check("R1 unmasked grant", d, 16'h800C);
        rd(4'd1, d); wr(4'd0, 16'h8000);

        // R1 priority mask limit, R6 inta acknowledge
        wr(4'd4, 16'h0001);
        pulse(3'b000, 2'b00, 4'b0010);
        settle();
        check("R1 level above pmask no irq", {15'b0, irq}, 16'h0000);
        wr(4'd4, 16'h0005);
        settle();
        rd(4'd2, d); check("R1 pmask raised grant", d, 16'h800D);
        @(negedge clk); inta = 1'b1;
        #1 check("R6 ack_vec on inta", 16'(ack_vec), 16'h000D);
        @(negedge clk); inta = 1'b0;
        #1 check("R6 irq falls after inta", {15'b0, irq}, 16'h0000);
        rd(4'd5, d); check("R6 isr set", d, 16'h0020);
        wr(4'd4, 16'h0007);

        // R4 blocking at same level, R7 specific EOI
        wr(4'd14, 16'h5);
        pulse(3'b000, 2'b00, 4'b1000);
        settle();
        check("R4 blocked by in-service", {15'b0, irq}, 16'h0000);
        wr(4'd0, 16'h000D);
        settle();
        rd(4'd5, d); check("R7 specific EOI clears", d, 16'h0000);
        rd(4'd2, d); check("R7 unblocked grant", d, 16'h800F);
        rd(4'd1, d);

        // R8 non-specific EOI with two in service
        pulse(3'b000, 2'b00, 4'b0001);
        settle();
        rd(4'd1, d); check("R2 level 0 preempts", d, 16'h800C);
        rd(4'd5, d); check("R6 two in service", d, 16'h0090);
        wr(4'd0, 16'h8000);
        rd(4'd5, d); check("R8 non-specific EOI", d, 16'h0080);
        wr(4'd0, 16'h8000);
        rd(4'd5, d); check("R8 second EOI", d, 16'h0000);

        // R9 poll-status read does not acknowledge
        pulse(3'b000, 2'b10, 4'b0000);
        settle();
        rd(4'd2, d); rd(4'd2, d);
        check("R9 poll status value", d, 16'h800B);
        check("R9 irq kept", {15'b0, irq}, 16'h0001);
        rd(4'd5, d); check("R9 isr untouched", d, 16'h0000);
        rd(4'd1, d); wr(4'd0, 16'h8000);

        // R6 timer status write then ack clears sub-bit
        wr(4'd7, 16'h0002);
        settle();
        rd(4'd1, d); check("R3 timer sub 1 vector", d, 16'h8012);
        rd(4'd7, d); check("R6 timer status cleared", d, 16'h0000);
        wr(4'd0, 16'h0012);

        // R4 in-service written by software blocks timer
        wr(4'd5, 16'h0001);
        pulse(3'b001, 2'b00, 4'b0000);
        settle();
        check("R4 written isr blocks", {15'b0, irq}, 16'h0000);
        rd(4'd6, d); check("R12 request bit0 from timer", d, 16'h0001);
        wr(4'd5, 16'h0000);
        settle();
        rd(4'd2, d); check("R3 timer sub 0 vector", d, 16'h8008);
        rd(4'd15, d); check("R12 unlisted reads zero", d, 16'h0000);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule